// File: doc/BRIEF.md
# Multicast Hash Filter

This block decides whether a received frame addressed to a group (multicast) destination should be kept. The six destination-address bytes arrive one per valid strobe in the order they appear on the line. The first byte is marked by a start pulse. The block tests the first transmitted bit to recognise a group address. It folds all 48 address bits through a CRC-32 and uses the six top bits of the running remainder to pick one bucket of a 64-bit hash mask. Software loads the mask beforehand as four 16-bit words.

The decision, the group flag and the bucket number are registered and presented with a one-cycle done strobe. These outputs then hold until the next decision. A hit only means the address may be wanted. A later stage is expected to make the exact match.

Top module: `mcast_hash_filter`

## Requirements
- R1: After the synchronous active-low reset, done, accept, is_mcast and hash_idx are 0, and the mask is all zeros, so every group address is rejected until the mask is written.
- R2: is_mcast reports bit 0 of the first address byte. Bytes are sent least significant bit first, so this is the first bit on the line.
- R3: The remainder starts at 0xFFFFFFFF. Each address bit b is taken in order: byte 0 first, bit 0 first within a byte. For each bit, fb = rem[31] ^ b, then rem is shifted left by one and XORed with 0x04C11DB7 when fb is 1. hash_idx equals rem[31:26] after all 48 bits, with no final inversion.
- R4: accept is 1 exactly when is_mcast is 1 and mask bit hash_idx is 1.
- R5: done is high for exactly one cycle, in the cycle after the clock edge that takes the sixth address byte. accept, is_mcast and hash_idx keep their values until the next done.
- R6: Cycles with byte_valid low are skipped. Gaps of any length between address bytes do not change the result.
- R7: addr_start qualified by byte_valid always begins a new address and discards any partial one. Valid bytes that arrive with no address in progress are ignored and produce no done.
- R8: For an address whose first bit is 0, done still fires, with is_mcast 0 and accept 0.
- R9: A write with mask_wr_en high loads mask_wr_data into word mask_wr_sel. Word w holds mask bits 16w+15 down to 16w, so word 0 holds bits 15:0. The other words are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_start | input | 1 | Marks the first byte of an address (taken only with byte_valid) |
| byte_valid | input | 1 | byte_data holds an address byte |
| byte_data | input | 8 | Address byte, bit 0 is first on the line |
| mask_wr_en | input | 1 | Mask word write strobe |
| mask_wr_sel | input | 2 | Mask word number |
| mask_wr_data | input | 16 | Mask word value |
| done | output | 1 | One-cycle decision strobe |
| is_mcast | output | 1 | Address was a group address |
| accept | output | 1 | Frame passes the hash filter |
| hash_idx | output | 6 | Selected mask bucket |

## Verification
Several internal faults show up at the next done strobe. A corrupted remainder shows as a wrong hash_idx. A miscounted byte position shows as done arriving one byte early or late, or not at all. A bad mask word shows as an accept that disagrees with the bucket the bench predicts. For this reason every address is checked in the cycle right after its sixth byte. Random masks and addresses, with random idle gaps between bytes, give the word mapping and the bit order many distinct values. Directed cases cover an interrupted address and stray bytes, where a wrong sequencer state would show as a done that should not appear.

// File: rtl/mcf_pkg.sv
// Shared constants for the multicast hash filter.
// Assumes the CRC-32 line polynomial and a 64-bucket mask.
package mcf_pkg;
    localparam int unsigned ADDR_BYTES  = 6;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned CRC_W       = 32;
    localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
    localparam int unsigned MASK_BITS   = 64;
    localparam int unsigned WORD_W      = 16;
endpackage

// File: rtl/mcf_crc_byte.sv
// Combinational CRC update over one byte, least significant bit first.
// Assumes a non-reflected remainder shifted left; no final inversion.
module mcf_crc_byte #(
    parameter int unsigned CRC_W  = mcf_pkg::CRC_W,
    parameter int unsigned DATA_W = mcf_pkg::BYTE_W,
    parameter logic [CRC_W-1:0] POLY = mcf_pkg::CRC_POLY
) (
    input  logic [CRC_W-1:0]  rem_in,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  rem_out
);
    logic [CRC_W-1:0] stage [DATA_W+1];

    assign stage[0] = rem_in;

    // One shift-and-fold stage per data bit, bit 0 first.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic fb;
        assign fb = stage[b][CRC_W-1] ^ data[b];
        assign stage[b+1] = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign rem_out = stage[DATA_W];
endmodule

// File: rtl/mcf_addr_seq.sv
// Tracks the byte position of the address being received.
// Assumes addr_start counts only together with byte_valid; a start restarts.
module mcf_addr_seq #(
    parameter int unsigned NBYTES = mcf_pkg::ADDR_BYTES,
    localparam int unsigned CNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_start,
    input  logic byte_valid,
    output logic take,
    output logic first,
    output logic last
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(NBYTES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] pos_now;

    // Decode which byte, if any, is taken this cycle.
    always_comb begin
        first   = byte_valid && addr_start;
        take    = first || (byte_valid && busy_q);
        pos_now = first ? '0 : pos_q;
        last    = take && (pos_now == LAST_POS);
    end

    // Advance the position and close the address after its last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pos_q  <= '0;
        end else if (take) begin
            busy_q <= !last;
            pos_q  <= last ? '0 : pos_now + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mcf_hash_mask.sv
// Word-written hash mask with a single bucket lookup.
// Assumes MASK_BITS is a multiple of WORD_W; word w holds bits w*WORD_W upward.
module mcf_hash_mask #(
    parameter int unsigned MASK_BITS = mcf_pkg::MASK_BITS,
    parameter int unsigned WORD_W    = mcf_pkg::WORD_W,
    localparam int unsigned NWORDS   = MASK_BITS / WORD_W,
    localparam int unsigned SEL_W    = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int unsigned IDX_W    = $clog2(MASK_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_bit
);
    logic [MASK_BITS-1:0] mask_q;

    // One register word per slice, loaded when its number is selected.
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[w*WORD_W +: WORD_W] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(w)))
                mask_q[w*WORD_W +: WORD_W] <= wr_data;
        end
    end

    assign rd_bit = mask_q[rd_idx];
endmodule

// File: rtl/mcast_hash_filter.sv
// Top: hashes a streamed destination address and looks it up in the mask.
// Assumes one byte per valid cycle; outputs are registered at the last byte.
module mcast_hash_filter #(
    parameter int unsigned NBYTES    = mcf_pkg::ADDR_BYTES,
    parameter int unsigned CRC_W     = mcf_pkg::CRC_W,
    parameter int unsigned MASK_BITS = mcf_pkg::MASK_BITS,
    parameter int unsigned WORD_W    = mcf_pkg::WORD_W,
    localparam int unsigned IDX_W    = $clog2(MASK_BITS),
    localparam int unsigned SEL_W    = $clog2(MASK_BITS / WORD_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       addr_start,
    input  logic                       byte_valid,
    input  logic [mcf_pkg::BYTE_W-1:0] byte_data,
    input  logic                       mask_wr_en,
    input  logic [SEL_W-1:0]           mask_wr_sel,
    input  logic [WORD_W-1:0]          mask_wr_data,
    output logic                       done,
    output logic                       is_mcast,
    output logic                       accept,
    output logic [IDX_W-1:0]           hash_idx
);
    logic             take, first, last;
    logic [CRC_W-1:0] rem_q, rem_base, rem_next;
    logic             grp_q, grp_now;
    logic [IDX_W-1:0] idx_next;
    logic             bucket_hit;

    mcf_addr_seq #(.NBYTES(NBYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .addr_start(addr_start),
        .byte_valid(byte_valid), .take(take), .first(first), .last(last)
    );

    // Seed the remainder on the first byte, otherwise continue.
    always_comb begin
        rem_base = first ? CRC_W'(mcf_pkg::CRC_SEED) : rem_q;
        grp_now  = first ? byte_data[0] : grp_q;
        idx_next = rem_next[CRC_W-1 -: IDX_W];
    end

    mcf_crc_byte #(.CRC_W(CRC_W), .DATA_W(mcf_pkg::BYTE_W),
                   .POLY(CRC_W'(mcf_pkg::CRC_POLY))) u_crc (
        .rem_in(rem_base), .data(byte_data), .rem_out(rem_next)
    );

    mcf_hash_mask #(.MASK_BITS(MASK_BITS), .WORD_W(WORD_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(mask_wr_en), .wr_sel(mask_wr_sel),
        .wr_data(mask_wr_data), .rd_idx(idx_next), .rd_bit(bucket_hit)
    );

    // Hold the running remainder and the group flag of the open address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            grp_q <= 1'b0;
        end else if (take) begin
            rem_q <= rem_next;
            grp_q <= grp_now;
        end
    end

    // Register the decision at the last byte; pulse done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            is_mcast <= 1'b0;
            accept   <= 1'b0;
            hash_idx <= '0;
        end else begin
            done <= last;
            if (last) begin
                is_mcast <= grp_now;
                accept   <= grp_now && bucket_hit;
                hash_idx <= idx_next;
            end
        end
    end
endmodule

// File: rtl/mcf_checker.sv
// Port-level properties of the multicast hash filter, bound to the top.
module mcf_checker (
    input logic clk,
    input logic rst_n,
    input logic byte_valid,
    input logic done,
    input logic is_mcast,
    input logic accept
);
    logic rst_seen_q;

    // Remember that the previous edge had reset asserted.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // Outputs are quiet right after a reset cycle.
    always_ff @(posedge clk) begin
        if (rst_seen_q === 1'b1)
            assert_reset_quiet_R1: assert (!done && !accept && !is_mcast);
    end

    assert_accept_needs_group_R8: assert property (@(posedge clk)
        disable iff (!rst_n) accept |-> is_mcast);

    assert_done_single_R5: assert property (@(posedge clk)
        disable iff (!rst_n) done |=> !done);

    assert_done_after_byte_R6: assert property (@(posedge clk)
        disable iff (!rst_n) done |-> $past(byte_valid));

    assert_accept_hold_R5: assert property (@(posedge clk)
        disable iff (!rst_n) !done |-> $stable(accept));
endmodule

bind mcast_hash_filter mcf_checker u_mcf_checker (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
    .done(done), .is_mcast(is_mcast), .accept(accept)
);

// File: tb/mcast_hash_filter_bench.sv
module mcast_hash_filter_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_start = 1'b0, byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        mask_wr_en = 1'b0;
    logic [1:0]  mask_wr_sel = '0;
    logic [15:0] mask_wr_data = '0;
    logic        done, is_mcast, accept;
    logic [5:0]  hash_idx;

    int checks = 0, fails = 0;
    logic [63:0] mask_m = '0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcast_hash_filter u_mcast_hash_filter (
        .clk(clk), .rst_n(rst_n), .addr_start(addr_start),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .mask_wr_en(mask_wr_en), .mask_wr_sel(mask_wr_sel),
        .mask_wr_data(mask_wr_data), .done(done), .is_mcast(is_mcast),
        .accept(accept), .hash_idx(hash_idx));

    function automatic logic [5:0] model_idx(input logic [47:0] a);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = r[31] ^ a[i];
            r = {r[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
        end
        return r[31:26];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_byte(input logic st, input logic [7:0] d);
        addr_start = st; byte_valid = 1'b1; byte_data = d;
        @(negedge clk);
        addr_start = 1'b0; byte_valid = 1'b0;
    endtask

    // Send an address (byte i = a[8i+:8]) with up to max_gap idle cycles between bytes; check the result.
    task automatic send_addr(input logic [47:0] a, input int max_gap, input string tag);
        logic [5:0] ei = model_idx(a);
        logic em = a[0];
        for (int i = 0; i < 6; i++) begin
            if (i > 0) begin
                int g = (max_gap > 0) ? $urandom_range(max_gap, 0) : 0;
                repeat (g) begin
                    @(negedge clk);
                    check({tag, " R6 no early done"}, done, 0);
                end
            end
            put_byte(i == 0, a[8*i +: 8]);
            if (i < 5) check({tag, " R5 no done before sixth"}, done, 0);
        end
        check({tag, " R5 done"}, done, 1);
        check({tag, " R2 group flag"}, is_mcast, em);
        check({tag, " R3 hash index"}, hash_idx, ei);
        check({tag, " R4 R8 accept"}, accept, em & mask_m[ei]);
        @(negedge clk);
        check({tag, " R5 single pulse"}, done, 0);
        check({tag, " R5 accept held"}, accept, em & mask_m[ei]);
    endtask

    task automatic write_word(input logic [1:0] w, input logic [15:0] v);
        mask_wr_en = 1'b1; mask_wr_sel = w; mask_wr_data = v;
        @(negedge clk);
        mask_wr_en = 1'b0;
        mask_m[16*w +: 16] = v;
    endtask

    // Find an address that hashes to the wanted bucket with the group bit set.
    function automatic logic [47:0] addr_for(input logic [5:0] want, input logic [47:0] base);
        logic [47:0] a = base | 48'h1;
        for (int k = 0; k < 4096; k++) begin
            if (model_idx(a) == want) return a;
            a = a + 48'h100;
        end
        return a;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset done", done, 0);
        check("R1 reset accept", accept, 0);
        check("R1 reset group", is_mcast, 0);
        check("R1 reset index", hash_idx, 0);
        send_addr(48'h0000_5E00_0001 | 48'h1, 0, "R1 zero mask rejects");

        // R9: word 0 bit 0 and word 3 bit 15 map to buckets 0 and 63.
        write_word(2'd0, 16'h0001);
        send_addr(addr_for(6'd0, 48'h0012_3400_0000), 0, "R9 word0 bit0");
        send_addr(addr_for(6'd15, 48'h0022_0000_0000), 0, "R9 word0 bit15 clear");
        write_word(2'd3, 16'h8000);
        send_addr(addr_for(6'd63, 48'h0033_0000_0000), 0, "R9 word3 bit15");
        send_addr(addr_for(6'd16, 48'h0044_0000_0000), 1, "R9 word1 untouched");

        // R8: individual address with full mask.
        for (int w = 0; w < 4; w++) write_word(w[1:0], 16'hFFFF);
        send_addr(48'hFFFF_FFFF_FFFE, 0, "R8 individual full mask");
        send_addr(48'hFFFF_FFFF_FFFF, 0, "R4 broadcast full mask");

        // R7: interrupted address, then a fresh one wins.
        write_word(2'd1, 16'h5A5A);
        put_byte(1'b1, 8'h01); put_byte(1'b0, 8'h22); put_byte(1'b0, 8'h33);
        send_addr(48'h0A0B_0C0D_0E01, 2, "R7 restart");
        // R7: stray bytes without a start give no done.
        for (int i = 0; i < 8; i++) begin
            put_byte(1'b0, 8'(i));
            check("R7 stray byte no done", done, 0);
        end
        @(negedge clk);
        check("R7 stray byte no done", done, 0);

        // Random masks and addresses with gaps.
        for (int n = 0; n < 120; n++) begin
            if (n % 10 == 0)
                for (int w = 0; w < 4; w++) write_word(w[1:0], 16'($urandom));
            send_addr({$urandom, 16'($urandom)}, 3, "random");
        end

        // R1: reset mid-run clears the mask.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mask_m = '0;
        check("R1 reset done", done, 0);
        send_addr(addr_for(6'd42, 48'h0055_0000_0000), 0, "R1 mask cleared");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule